// File: doc/BRIEF.md
# Class-D Output Driver Enable Sequencer

This controller decides, on every clock, whether the output drivers of a two-channel class-D power stage may switch. It takes a chip-enable pin, an asynchronous power-on-reset, flags from the analog comparators (junction hot, junction back inside the safe band, supply sagging) and one short-circuit flag per channel. From these it runs a timed soft-start when enable rises and a short lockout when enable falls. It also applies a separate recovery rule to each fault. The over-temperature rule uses a hysteresis band with a dwell timer. The short-circuit rule uses a detection filter followed by a fixed off-time and a retry loop. An undervoltage removes only the drivers and leaves every timer and state intact.

All durations are parameters counted in clock cycles. The defaults assume a 1 MHz clock: 3400 cycles of soft-start, 30 of power-down, 47000 of thermal dwell and of short off-time, and 14 of short filter. Every comparator flag and the enable pin pass through a two-flop synchronizer, so each of them reaches the logic two edges after it changes. Three sticky event bits record thermal trips, qualified shorts and undervoltage, and a synchronous clear strobe resets them. The block carries no data stream, so all of its pins are plain level signals with no handshake.

Top module: `amp_guard_seq`

## Requirements
- R1: While `por_i` is high, the block is held in power-down immediately and without waiting for a clock edge: `drv_en_o`, `ramp_o` and all three sticky bits are 0. After release with enable high, a full soft-start is needed again.
- R2: When `chip_en_i` is driven high, `ramp_o` rises at the 3rd rising edge and stays high for exactly T_UP cycles. `drv_en_o` rises at edge 3+T_UP, the same edge at which `ramp_o` falls. The two outputs are never high together.
- R3: When `chip_en_i` is driven low, `drv_en_o` and `ramp_o` are low from the 3rd edge onwards. A power-down interval of T_DOWN cycles follows, during which a new enable is not acted on. A new soft-start begins only at the edge after that interval ends.
- R4: Every comparator flag and the enable pin take effect two edges after they change. A flag change driven just before edge 1 has no effect on the outputs until edge 2.
- R5: When `hot_i` is high, `drv_en_o` is low from the 2nd edge after it rises.
- R6: After a thermal trip, with `hot_i` low, the drivers return only after `safe_i` has been seen high on T_DWELL consecutive synchronized cycles. Any cycle in which `safe_i` is low restarts the count from zero.
- R7: A short is qualified when bit c of `short_i` (bit c is channel c) is seen high on T_FILT consecutive synchronized cycles. The drivers then go low at edge 2+T_FILT after the bit rises. A pulse shorter than T_FILT cycles has no effect on `drv_en_o`.
- R8: A qualified short keeps the drivers off for T_OFF cycles, and then the drivers are released. If the short is still present, it is qualified again after another T_FILT cycles and the off period repeats. This continues until the short clears.
- R9: While `uv_i` is high, `drv_en_o` is low. When `uv_i` falls, `drv_en_o` returns two edges later with no new soft-start, because the sequencer and timers keep their state.
- R10: `drv_en_o` is high only when the sequencer has finished soft-start and the synchronized undervoltage, thermal-block and short-block conditions are all clear. Each fault holds the drivers off on its own.
- R11: `hot_stk_o`, `short_stk_o` and `uv_stk_o` each set on their event (synchronized hot flag, qualified short, synchronized undervoltage flag) and hold until a `clr_i` strobe. A set condition present in the same cycle as the strobe wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| chip_en_i | input | 1 | Chip enable pin, asynchronous |
| hot_i | input | 1 | Junction over-temperature comparator |
| safe_i | input | 1 | Junction inside safe temperature band |
| uv_i | input | 1 | Supply undervoltage comparator |
| short_i | input | NCH | Per-channel short-circuit comparators, bit c is channel c |
| clr_i | input | 1 | Synchronous strobe clearing the sticky bits |
| drv_en_o | output | 1 | Output drivers allowed to switch |
| ramp_o | output | 1 | Soft-start in progress |
| hot_stk_o | output | 1 | Sticky: thermal trip seen |
| short_stk_o | output | 1 | Sticky: qualified short seen |
| uv_stk_o | output | 1 | Sticky: undervoltage seen |

## Verification
A wrong sequencer state appears first on `ramp_o` and `drv_en_o`. A one-cycle error in the soft-start or power-down counters moves the rising edge of either output by exactly that cycle, and the bench samples both outputs every cycle around those edges. A fault timer left in the wrong state shows as a driver release that comes too early or too late, or that never comes. Such an error is visible within T_DWELL, T_FILT or T_OFF cycles of the stimulus. A stuck sticky bit shows at the next clear strobe.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;
  typedef enum logic [1:0] {
    PW_OFF  = 2'd0,
    PW_RAMP = 2'd1,
    PW_ON   = 2'd2,
    PW_DOWN = 2'd3
  } pwr_state_t;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic meta_q, stab_q;
      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          meta_q <= 1'b0;
          stab_q <= 1'b0;
        end else begin
          meta_q <= d[b];
          stab_q <= meta_q;
        end
      end
      assign q[b] = stab_q;
    end
  endgenerate
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import amp_guard_pkg::*;
#(
  parameter int T_UP   = 3400,
  parameter int T_DOWN = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic ramp,
  output logic on
);
  localparam int MAXT = (T_UP > T_DOWN) ? T_UP : T_DOWN;
  localparam int CW   = $clog2(MAXT + 1);

  pwr_state_t    st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st_q  <= PW_OFF;
      cnt_q <= '0;
    end else begin
      case (st_q)
        PW_OFF: if (en) begin
          st_q  <= PW_RAMP;
          cnt_q <= '0;
        end
        PW_RAMP: if (!en) begin
          st_q  <= PW_DOWN;
          cnt_q <= '0;
        end else if (cnt_q == CW'(T_UP - 1)) begin
          st_q  <= PW_ON;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        PW_ON: if (!en) begin
          st_q  <= PW_DOWN;
          cnt_q <= '0;
        end
        default: if (cnt_q == CW'(T_DOWN - 1)) begin
          st_q  <= PW_OFF;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign ramp = (st_q == PW_RAMP);
  assign on   = (st_q == PW_ON);

  // R2
  on_after_ramp_chk: assert property (@(posedge clk) disable iff (rst)
    (on && !$past(on)) |-> $past(ramp));
  // R3
  down_no_ramp_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(st_q) == PW_DOWN && st_q != PW_DOWN) |-> st_q == PW_OFF);
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard #(
  parameter int T_DWELL = 47000
) (
  input  logic clk,
  input  logic rst,
  input  logic hot,
  input  logic safe,
  output logic blk
);
  localparam int CW = $clog2(T_DWELL + 1);

  logic          off_q;
  logic [CW-1:0] dwell_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      off_q   <= 1'b0;
      dwell_q <= '0;
    end else if (hot) begin
      off_q   <= 1'b1;
      dwell_q <= '0;
    end else if (off_q) begin
      if (!safe) begin
        dwell_q <= '0;
      end else if (dwell_q == CW'(T_DWELL - 1)) begin
        off_q   <= 1'b0;
        dwell_q <= '0;
      end else begin
        dwell_q <= dwell_q + 1'b1;
      end
    end
  end

  assign blk = hot | off_q;

  // R5
  hot_latch_chk: assert property (@(posedge clk) disable iff (rst)
    hot |=> off_q);
  // R6
  release_safe_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(off_q) |-> $past(safe) && !$past(hot));
endmodule

// File: rtl/short_guard.sv
module short_guard #(
  parameter int NCH    = 2,
  parameter int T_FILT = 14,
  parameter int T_OFF  = 47000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] sc,
  output logic           blk,
  output logic           trip
);
  localparam int FW = $clog2(T_FILT + 1);
  localparam int OW = $clog2(T_OFF + 1);

  logic           hold_q;
  logic [OW-1:0]  off_q;
  logic [NCH-1:0] qual;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [FW-1:0] run_q;
      always_ff @(posedge clk or posedge rst) begin
        if (rst)                    run_q <= '0;
        else if (hold_q || !sc[c])  run_q <= '0;
        else if (run_q != FW'(T_FILT - 1)) run_q <= run_q + 1'b1;
      end
      assign qual[c] = !hold_q && sc[c] && (run_q == FW'(T_FILT - 1));
    end
  endgenerate

  assign trip = |qual;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      hold_q <= 1'b0;
      off_q  <= '0;
    end else if (!hold_q) begin
      if (trip) begin
        hold_q <= 1'b1;
        off_q  <= '0;
      end
    end else if (off_q == OW'(T_OFF - 1)) begin
      hold_q <= 1'b0;
      off_q  <= '0;
    end else begin
      off_q <= off_q + 1'b1;
    end
  end

  assign blk = hold_q;

  // R7
  trip_needs_short_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_q) |-> $past(|sc));
  // R8
  hold_no_trip_chk: assert property (@(posedge clk) disable iff (rst)
    hold_q |-> !trip);
endmodule

// File: rtl/amp_guard_seq.sv
module amp_guard_seq #(
  parameter int NCH     = 2,
  parameter int T_UP    = 3400,
  parameter int T_DOWN  = 30,
  parameter int T_DWELL = 47000,
  parameter int T_FILT  = 14,
  parameter int T_OFF   = 47000
) (
  input  logic           clk,
  input  logic           por_i,
  input  logic           chip_en_i,
  input  logic           hot_i,
  input  logic           safe_i,
  input  logic           uv_i,
  input  logic [NCH-1:0] short_i,
  input  logic           clr_i,
  output logic           drv_en_o,
  output logic           ramp_o,
  output logic           hot_stk_o,
  output logic           short_stk_o,
  output logic           uv_stk_o
);
  localparam int SW = NCH + 4;

  logic [SW-1:0]  raw, syn;
  logic           en_s, hot_s, safe_s, uv_s;
  logic [NCH-1:0] sc_s;
  logic           pw_on, th_blk, sc_blk, sc_trip;

  assign raw = {short_i, uv_i, safe_i, hot_i, chip_en_i};

  flag_sync #(.W(SW)) u_sync (
    .clk(clk), .rst(por_i), .d(raw), .q(syn)
  );

  assign en_s   = syn[0];
  assign hot_s  = syn[1];
  assign safe_s = syn[2];
  assign uv_s   = syn[3];
  assign sc_s   = syn[4 +: NCH];

  pwr_seq #(.T_UP(T_UP), .T_DOWN(T_DOWN)) u_pwr (
    .clk(clk), .rst(por_i), .en(en_s), .ramp(ramp_o), .on(pw_on)
  );

  thermal_guard #(.T_DWELL(T_DWELL)) u_therm (
    .clk(clk), .rst(por_i), .hot(hot_s), .safe(safe_s), .blk(th_blk)
  );

  short_guard #(.NCH(NCH), .T_FILT(T_FILT), .T_OFF(T_OFF)) u_short (
    .clk(clk), .rst(por_i), .sc(sc_s), .blk(sc_blk), .trip(sc_trip)
  );

  assign drv_en_o = pw_on & ~uv_s & ~th_blk & ~sc_blk;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      hot_stk_o   <= 1'b0;
      short_stk_o <= 1'b0;
      uv_stk_o    <= 1'b0;
    end else begin
      hot_stk_o   <= hot_s   | (hot_stk_o   & ~clr_i);
      short_stk_o <= sc_trip | (short_stk_o & ~clr_i);
      uv_stk_o    <= uv_s    | (uv_stk_o    & ~clr_i);
    end
  end

  // R2
  ramp_drv_excl_chk: assert property (@(posedge clk) disable iff (por_i)
    !(ramp_o && drv_en_o));
  // R9
  uv_gate_chk: assert property (@(posedge clk) disable iff (por_i)
    uv_s |-> !drv_en_o);
  // R11
  uv_sticky_chk: assert property (@(posedge clk) disable iff (por_i)
    uv_s |=> uv_stk_o);
  // R10
  fault_gate_chk: assert property (@(posedge clk) disable iff (por_i)
    (hot_s || sc_blk) |-> !drv_en_o);
endmodule

// File: tb/test_amp_guard_seq.sv
module test_amp_guard_seq;
  localparam int NC = 2;
  localparam int TU = 12;
  localparam int TD = 5;
  localparam int TW = 20;
  localparam int TF = 4;
  localparam int TO = 16;

  logic          clk = 1'b0;
  logic          por, en, hot, safe, uv, clr;
  logic [NC-1:0] sc;
  logic          drv, ramp, hstk, sstk, ustk;
  int            ntests = 0;
  int            nfail  = 0;

  always #2 clk = ~clk;

  amp_guard_seq #(.NCH(NC), .T_UP(TU), .T_DOWN(TD), .T_DWELL(TW),
                  .T_FILT(TF), .T_OFF(TO)) i_amp_guard_seq (
    .clk(clk), .por_i(por), .chip_en_i(en), .hot_i(hot), .safe_i(safe),
    .uv_i(uv), .short_i(sc), .clr_i(clr), .drv_en_o(drv), .ramp_o(ramp),
    .hot_stk_o(hstk), .short_stk_o(sstk), .uv_stk_o(ustk)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clear_sticky();
    clr = 1'b1; step(1); clr = 1'b0;
  endtask

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    por = 1'b1; en = 1'b0; hot = 1'b0; safe = 1'b1; uv = 1'b0; clr = 1'b0; sc = '0;
    step(3);
    chk("R1 reset drv", drv, 0);
    chk("R1 reset ramp", ramp, 0);
    chk("R1 reset sticky", {hstk, sstk, ustk}, 0);
    por = 1'b0;
    step(4);

    // R2: per-cycle sweep across the soft-start
    en = 1'b1;
    for (int c = 1; c <= TU + 5; c++) begin
      step(1);
      chk("R2 ramp", ramp, (c >= 3 && c < 3 + TU));
      chk("R2 drv", drv, (c >= 3 + TU));
    end

    // R4 / R9: undervoltage soft fault
    uv = 1'b1;
    step(1); chk("R4 uv latency", drv, 1);
    step(1); chk("R9 uv off", drv, 0);
    step(5); chk("R9 uv hold", drv, 0);
    chk("R11 uv sticky", ustk, 1);
    uv = 1'b0;
    step(1); chk("R4 uv release latency", drv, 0);
    step(1); chk("R9 uv back", drv, 1);
    chk("R9 no re-ramp", ramp, 0);
    clear_sticky();
    chk("R11 uv cleared", ustk, 0);
    uv = 1'b1; step(3);
    clear_sticky();
    chk("R11 set beats clear", ustk, 1);
    uv = 1'b0; step(3);
    clear_sticky();
    chk("R11 cleared again", ustk, 0);
    chk("R9 drv after uv", drv, 1);

    // R5 / R6: thermal trip and dwell
    hot = 1'b1; safe = 1'b0;
    step(1); chk("R5 hot latency", drv, 1);
    step(1); chk("R5 hot off", drv, 0);
    step(3); hot = 1'b0;
    step(6); chk("R6 no safe no release", drv, 0);
    safe = 1'b1;
    step(1 + TW); chk("R6 dwell not done", drv, 0);
    step(1);      chk("R6 dwell done", drv, 1);
    chk("R11 hot sticky", hstk, 1);
    clear_sticky();
    chk("R11 hot cleared", hstk, 0);

    // R6: dwell restart on a safe dropout
    hot = 1'b1; safe = 1'b0; step(3);
    hot = 1'b0; safe = 1'b1; step(6);
    safe = 1'b0; step(1); safe = 1'b1;
    step(TW + 1); chk("R6 restart not done", drv, 0);
    step(1);      chk("R6 restart done", drv, 1);
    clear_sticky();

    // R10: concurrent thermal and undervoltage
    uv = 1'b1; hot = 1'b1; safe = 1'b0; step(3);
    hot = 1'b0; safe = 1'b1;
    step(TW + 4); chk("R10 uv still holds", drv, 0);
    uv = 1'b0;
    step(2); chk("R10 all clear", drv, 1);
    clear_sticky();
    chk("R11 all cleared", {hstk, sstk, ustk}, 0);

    // R7 / R8: glitch-length sweep on every channel
    for (int ch = 0; ch < NC; ch++) begin
      for (int g = 1; g <= TF + 1; g++) begin
        sc[ch] = 1'b1; step(g);
        sc[ch] = 1'b0; step(2 + TF - g);
        chk("R7 filter", drv, (g < TF));
        step(TO + 2);
        chk("R8 release", drv, 1);
        chk("R11 short sticky", sstk, (g >= TF));
        clear_sticky();
      end
    end

    // R8: persistent short retry loop
    sc[0] = 1'b1;
    step(2 + TF);  chk("R8 first trip", drv, 0);
    step(TO);      chk("R8 retry release", drv, 1);
    step(TF - 1);  chk("R8 retry window", drv, 1);
    step(1);       chk("R8 second trip", drv, 0);
    sc[0] = 1'b0;
    step(TO + 3);  chk("R8 short cleared", drv, 1);
    clear_sticky();

    // R3: power-down and lockout
    en = 1'b0;
    step(2); chk("R3 en latency", drv, 1);
    step(1); chk("R3 off", drv, 0);
    step(TD + 3);
    en = 1'b1; step(4 + TU); chk("R2 back on", drv, 1);
    en = 1'b0; step(1); en = 1'b1;
    step(2);      chk("R3 pulse off", drv, 0);
    step(TD);     chk("R3 lockout", ramp, 0);
    step(1);      chk("R3 restart", ramp, 1);
    step(TU);     chk("R2 on after restart", drv, 1);

    // R1: reset mid-operation
    uv = 1'b1; step(3); uv = 1'b0;
    por = 1'b1; #1;
    chk("R1 async drv", drv, 0);
    chk("R1 async sticky", ustk, 0);
    step(2);
    por = 1'b0;
    step(2); chk("R1 needs ramp", ramp, 0);
    step(1); chk("R1 ramp again", ramp, 1);
    chk("R1 drv waits", drv, 0);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule